// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block takes an idle-high asynchronous serial line and rebuilds each character. A bit-timing engine runs off a 16x oversampling tick. It moves the character through a shift register into a holding data register, and it keeps a small set of status flags for software. Data length, parity (on or off, odd or even), one or two stop bits and a multiprocessor address bit are chosen through static configuration inputs. Baud generation is external. The tick input supplies the sampling rate.

The processor side is a minimal register port with two registers. A select input picks the data register when low and the status register when high. Reads are combinational. A status flag can be cleared only by writing 0 to its bit, and only after a status read has returned that bit as 1. While any error flag is set the receiver accepts no new character, so software must service the error first.

Top module: `serrx_unit`

## Requirements
- R1: After reset the status register reads 0 and the data register reads 0.
- R2: A start is accepted only if the line is still low on the 8th tick after the tick that first saw it low. A shorter low pulse produces no character and changes no flag.
- R3: Data bits are sampled every 16 ticks after the start check, least significant bit first. With `cfg_short`=1 seven bits are received and data bit 7 reads 0. With `cfg_short`=0 eight bits are received.
- R4: A character that ends with no error, while status bit 0 (full) is 0, is copied into the data register and sets status bit 0.
- R5: A character that ends while status bit 0 is 1 sets status bit 1 (overrun). The data register keeps its earlier value and the new character is discarded.
- R6: If the first stop bit is sampled as 0, status bit 2 (framing) is set, the character is still written to the data register, and status bit 0 stays 0. In two-stop mode the second stop bit is never checked.
- R7: With parity enabled and `cfg_mp_en`=0, status bit 3 (parity) is set when the number of ones in the data bits and the parity bit is even while `cfg_par_odd`=1, or odd while `cfg_par_odd`=0. The character is still written to the data register and status bit 0 stays 0.
- R8: While any of status bits 1, 2 or 3 is 1, no character is received and the data register does not change.
- R9: A write to the status register with bit i equal to 0 clears flag i (i = 0..3) only if the most recent status read, made after the previous status write, returned bit i as 1. Writing 1 has no effect, and a write with no such read clears nothing.
- R10: With `cfg_mp_en`=1 the bit after the data is a multiprocessor bit and no parity is checked. At the end of each character that bit is copied into status bit 4, which is read-only.
- R11: While `rx_en` is 0 no character is received. Status bits 0 to 4 and the data register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low aborts and blocks reception |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_short | input | 1 | 1 selects seven data bits, 0 selects eight |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | Two stop bits per character |
| cfg_mp_en | input | 1 | Multiprocessor format (address bit instead of parity) |
| bus_sel | input | 1 | Register select: 0 data, 1 status |
| bus_rd | input | 1 | Read strobe (arms status clearing) |
| bus_wr | input | 1 | Write strobe (status register only) |
| bus_wdata | input | 4 | Clear mask for status bits 0..3, active 0 |
| bus_rdata | output | 8 | Selected register contents |

## Verification
The assertions assume that the configuration inputs stay constant while a character is on the line. They also assume that `rxd` changes only at bit boundaries and holds each level for 16 ticks, and that the tick arrives at a steady rate. The stimulus meets these assumptions by asserting the tick on every clock. Each bit is driven on falling clock edges for exactly 16 cycles, the format is changed only while the line is idle, and the bus is driven on falling edges as well. Random characters are built with randomly chosen format, data, parity corruption and stop corruption. Directed cases cover a start glitch, overrun followed by blocking, partial clearing, a low second stop bit and receive disable.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

   // status bit positions; the clear mask uses the same positions
   localparam int FL_FULL = 0;
   localparam int FL_OVR  = 1;
   localparam int FL_FRM  = 2;
   localparam int FL_PAR  = 3;
   localparam int FL_MPB  = 4;
   localparam int NCLR    = 4;   // flags that software may clear

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_EXTRA,
      RX_STOP,
      RX_SKIP
   } rx_state_e;

endpackage

// File: rtl/serrx_frame.sv
module serrx_frame
   import serrx_pkg::*;
#(
   parameter int OS_RATE  = 16,
   parameter int DATA_MAX = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_en,
   input  logic                os_tick,
   input  logic                rxd,
   input  logic                hold,
   input  logic                cfg_short,
   input  logic                cfg_par_en,
   input  logic                cfg_mp_en,
   input  logic                cfg_two_stop,
   output logic                done,
   output logic [DATA_MAX-1:0] fdata,
   output logic                extra_bit,
   output logic                stop_bit,
   output logic                busy
);
   localparam int CW = $clog2(OS_RATE);
   localparam int BW = $clog2(DATA_MAX + 1);
   localparam logic [CW-1:0] MID  = CW'(OS_RATE / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);

   generate
      if (OS_RATE < 4 || (OS_RATE % 2) != 0) begin : g_bad_rate
         $error("serrx_frame: OS_RATE must be even and at least 4");
      end
      if (DATA_MAX < 5) begin : g_bad_len
         $error("serrx_frame: DATA_MAX must be at least 5");
      end
   endgenerate

   rx_state_e            state_q;
   logic [CW-1:0]        cnt_q;
   logic [BW-1:0]        bitn_q;
   logic [DATA_MAX-1:0]  shreg_q;
   logic [BW-1:0]        last_bit;

   assign last_bit = cfg_short ? BW'(DATA_MAX - 2) : BW'(DATA_MAX - 1);
   assign busy     = (state_q != RX_IDLE);
   assign fdata    = cfg_short ? {1'b0, shreg_q[DATA_MAX-1:1]} : shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RX_IDLE;
         cnt_q     <= '0;
         bitn_q    <= '0;
         shreg_q   <= '0;
         extra_bit <= 1'b0;
         stop_bit  <= 1'b1;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!rx_en) begin
            state_q <= RX_IDLE;
         end else if (os_tick) begin
            case (state_q)
               RX_IDLE: begin
                  if (!hold && !rxd) begin
                     state_q <= RX_START;
                     cnt_q   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt_q == MID) begin
                     cnt_q   <= '0;
                     bitn_q  <= '0;
                     state_q <= rxd ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt_q == LAST) begin
                     cnt_q   <= '0;
                     shreg_q <= {rxd, shreg_q[DATA_MAX-1:1]};
                     bitn_q  <= bitn_q + 1'b1;
                     if (bitn_q == last_bit)
                        state_q <= (cfg_par_en || cfg_mp_en) ? RX_EXTRA : RX_STOP;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_EXTRA: begin
                  if (cnt_q == LAST) begin
                     cnt_q     <= '0;
                     extra_bit <= rxd;
                     state_q   <= RX_STOP;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt_q == LAST) begin
                     cnt_q    <= '0;
                     stop_bit <= rxd;
                     done     <= 1'b1;
                     state_q  <= cfg_two_stop ? RX_SKIP : RX_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_SKIP: begin
                  if (cnt_q == LAST) state_q <= RX_IDLE;
                  else               cnt_q   <= cnt_q + 1'b1;
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   // R2 / R8: leaving idle needs enable, no pending error and a low line
   assert_start_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(rx_en && !hold && !rxd));

   // R11: dropping enable returns the engine to idle
   assert_disable_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !busy);

   // R4: a completion pulse lasts one cycle
   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/serrx_parity.sv
module serrx_parity #(
   parameter int DATA_MAX = 8
) (
   input  logic [DATA_MAX-1:0] fdata,
   input  logic                extra_bit,
   input  logic                cfg_par_en,
   input  logic                cfg_par_odd,
   input  logic                cfg_mp_en,
   output logic                perr
);
   logic ones_odd;

   assign ones_odd = (^fdata) ^ extra_bit;
   assign perr     = cfg_par_en && !cfg_mp_en && (ones_odd != cfg_par_odd);

endmodule

// File: rtl/serrx_regs.sv
module serrx_regs
   import serrx_pkg::*;
#(
   parameter int DATA_MAX = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic [DATA_MAX-1:0] fdata,
   input  logic                stop_bit,
   input  logic                perr,
   input  logic                extra_bit,
   input  logic                cfg_mp_en,
   input  logic                bus_sel,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [NCLR-1:0]     bus_wdata,
   output logic [DATA_MAX-1:0] bus_rdata,
   output logic                hold
);
   generate
      if (DATA_MAX < FL_MPB + 1) begin : g_bad_width
         $error("serrx_regs: DATA_MAX too small for the status layout");
      end
   endgenerate

   logic                flag_q  [NCLR];
   logic                armed_q [NCLR];
   logic [NCLR-1:0]     set_v;
   logic [DATA_MAX-1:0] data_q;
   logic                mpb_q;
   logic                rd_st, wr_st, load;

   assign rd_st = bus_rd && bus_sel;
   assign wr_st = bus_wr && bus_sel;
   assign load  = done && !flag_q[FL_FULL];

   assign set_v[FL_FULL] = load && stop_bit && !perr;
   assign set_v[FL_OVR]  = done && flag_q[FL_FULL];
   assign set_v[FL_FRM]  = load && !stop_bit;
   assign set_v[FL_PAR]  = load && perr;

   assign hold = flag_q[FL_OVR] || flag_q[FL_FRM] || flag_q[FL_PAR];

   for (genvar i = 0; i < NCLR; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[i]  <= 1'b0;
            armed_q[i] <= 1'b0;
         end else begin
            if (rd_st)      armed_q[i] <= flag_q[i];
            else if (wr_st) armed_q[i] <= 1'b0;
            if (set_v[i])
               flag_q[i] <= 1'b1;
            else if (wr_st && armed_q[i] && !bus_wdata[i])
               flag_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         mpb_q  <= 1'b0;
      end else begin
         if (load)              data_q <= fdata;
         if (done && cfg_mp_en) mpb_q  <= extra_bit;
      end
   end

   assign bus_rdata = bus_sel
      ? {{(DATA_MAX-FL_MPB-1){1'b0}}, mpb_q, flag_q[FL_PAR], flag_q[FL_FRM],
         flag_q[FL_OVR], flag_q[FL_FULL]}
      : data_q;

   // R5: overrun keeps the earlier character
   assert_overrun_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flag_q[FL_FULL]) |=> (flag_q[FL_OVR] && $stable(data_q)));

   // R9: the full flag falls only through an armed write of 0
   assert_clear_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[FL_FULL]) |-> $past(wr_st && armed_q[FL_FULL] && !bus_wdata[FL_FULL]));

   // R8: the data register changes only when a character ends with full clear
   assert_data_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_q) |-> $past(done && !flag_q[FL_FULL]));

   // R10: the multiprocessor bit moves only at the end of a character
   assert_mpb_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mpb_q) |-> $past(done && cfg_mp_en));

endmodule

// File: rtl/serrx_unit.sv
module serrx_unit
   import serrx_pkg::*;
#(
   parameter int OS_RATE  = 16,
   parameter int DATA_MAX = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_en,
   input  logic                os_tick,
   input  logic                rxd,
   input  logic                cfg_short,
   input  logic                cfg_par_en,
   input  logic                cfg_par_odd,
   input  logic                cfg_two_stop,
   input  logic                cfg_mp_en,
   input  logic                bus_sel,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [NCLR-1:0]     bus_wdata,
   output logic [DATA_MAX-1:0] bus_rdata
);
   logic                done, extra_bit, stop_bit, busy, perr, hold;
   logic [DATA_MAX-1:0] fdata;

   serrx_frame #(.OS_RATE(OS_RATE), .DATA_MAX(DATA_MAX)) u_frame (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
      .hold(hold), .cfg_short(cfg_short), .cfg_par_en(cfg_par_en),
      .cfg_mp_en(cfg_mp_en), .cfg_two_stop(cfg_two_stop), .done(done),
      .fdata(fdata), .extra_bit(extra_bit), .stop_bit(stop_bit), .busy(busy)
   );

   serrx_parity #(.DATA_MAX(DATA_MAX)) u_par (
      .fdata(fdata), .extra_bit(extra_bit), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_mp_en(cfg_mp_en), .perr(perr)
   );

   serrx_regs #(.DATA_MAX(DATA_MAX)) u_regs (
      .clk(clk), .rst_n(rst_n), .done(done), .fdata(fdata),
      .stop_bit(stop_bit), .perr(perr), .extra_bit(extra_bit),
      .cfg_mp_en(cfg_mp_en), .bus_sel(bus_sel), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .hold(hold)
   );

   // R8: no character may start while an error flag is pending
   assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !busy) |=> !busy);

endmodule

// File: tb/test_serrx_unit.sv
module test_serrx_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0;
   logic       os_tick = 1'b1;
   logic       rxd = 1'b1;
   logic       cfg_short = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
   logic       cfg_two_stop = 1'b0, cfg_mp_en = 1'b0;
   logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [3:0] bus_wdata = 4'hF;
   logic [7:0] bus_rdata;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] rv;
   logic       m_mpb = 1'b0;

   serrx_unit i_serrx_unit (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
      .cfg_short(cfg_short), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_two_stop(cfg_two_stop), .cfg_mp_en(cfg_mp_en), .bus_sel(bus_sel),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   always #2 clk = ~clk;

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      rxd = b;
      idle(16);
   endtask

   task automatic send(input logic [7:0] d, input bit xon, input logic xb,
                       input logic s1, input logic s2);
      int nb;
      nb = cfg_short ? 7 : 8;
      @(negedge clk);
      bit_out(1'b0);
      for (int i = 0; i < nb; i++) bit_out(d[i]);
      if (xon) bit_out(xb);
      bit_out(s1);
      if (cfg_two_stop) bit_out(s2);
      rxd = 1'b1;
      idle(20);
   endtask

   task automatic rd(input logic sel, output logic [7:0] v);
      @(negedge clk);
      bus_sel = sel;
      bus_rd  = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [3:0] m);
      @(negedge clk);
      bus_sel   = 1'b1;
      bus_wr    = 1'b1;
      bus_wdata = m;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = 4'hF;
   endtask

   task automatic clear_all();
      logic [7:0] t;
      rd(1'b1, t);
      wr(4'h0);
   endtask

   function automatic logic good_par(input logic [7:0] d, input bit odd);
      return (^d) ^ odd;
   endfunction

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] dA, d, exp_st, exp_d;
      bit bad_p, bad_s;
      void'($urandom(32'd1234));
      idle(3);
      rst_n = 1'b1;
      idle(2);
      rd(1'b1, rv); check("R1 status", rv, 8'h00);
      rd(1'b0, rv); check("R1 data", rv, 8'h00);
      rx_en = 1'b1;

      // R2: short low glitch
      @(negedge clk); rxd = 1'b0; idle(4); rxd = 1'b1; idle(40);
      rd(1'b1, rv); check("R2 glitch status", rv, 8'h00);

      // R4 clean 8-bit, then R5 overrun, then R8 blocking
      dA = 8'hA5;
      send(dA, 0, 0, 1, 1);
      rd(1'b1, rv); check("R4 full set", rv, 8'h01);
      rd(1'b0, rv); check("R3 R4 data", rv, dA);
      send(8'h3C, 0, 0, 1, 1);
      rd(1'b1, rv); check("R5 overrun", rv, 8'h03);
      rd(1'b0, rv); check("R5 data kept", rv, dA);
      send(8'h77, 0, 0, 1, 1);
      rd(1'b0, rv); check("R8 blocked data", rv, dA);
      // R9: clear only overrun, writing 1 to full has no effect
      rd(1'b1, rv);
      wr(4'b1101);
      rd(1'b1, rv); check("R9 partial clear", rv, 8'h01);
      wr(4'h0); // previous read arms full, this clears it
      rd(1'b1, rv); check("R9 armed clear", rv, 8'h00);
      send(8'h11, 0, 0, 1, 1);
      wr(4'h0); // no read since last write: no effect
      rd(1'b1, rv); check("R9 unarmed write", rv, 8'h01);
      clear_all();

      // R6: second stop low is ignored in two-stop mode
      cfg_two_stop = 1'b1;
      send(8'h5A, 0, 0, 1, 0);
      rd(1'b1, rv); check("R6 second stop", rv, 8'h01);
      rd(1'b0, rv); check("R6 second stop data", rv, 8'h5A);
      clear_all();
      cfg_two_stop = 1'b0;

      // R3: seven-bit mode clears bit 7
      cfg_short = 1'b1;
      send(8'hFF, 0, 0, 1, 1);
      rd(1'b0, rv); check("R3 short data", rv, 8'h7F);
      clear_all();
      cfg_short = 1'b0;

      // R10 / R11: multiprocessor bit survives disable
      cfg_mp_en = 1'b1;
      send(8'h42, 1, 1, 1, 1);
      rd(1'b1, rv); check("R10 mpb one", rv, 8'h11);
      clear_all();
      rx_en = 1'b0;
      send(8'h99, 1, 0, 1, 1);
      rd(1'b1, rv); check("R11 disabled status", rv, 8'h10);
      rd(1'b0, rv); check("R11 disabled data", rv, 8'h42);
      rx_en = 1'b1;
      send(8'h24, 1, 0, 1, 1);
      rd(1'b1, rv); check("R10 mpb zero", rv, 8'h01);
      clear_all();
      cfg_mp_en = 1'b0;
      m_mpb = 1'b0;

      // random frames: R3 R4 R6 R7 R10
      for (int k = 0; k < 60; k++) begin
         cfg_short    = $urandom_range(0, 1);
         cfg_par_en   = $urandom_range(0, 1);
         cfg_par_odd  = $urandom_range(0, 1);
         cfg_two_stop = $urandom_range(0, 1);
         cfg_mp_en    = ($urandom_range(0, 3) == 0);
         d     = 8'($urandom);
         bad_p = ($urandom_range(0, 4) == 0);
         bad_s = ($urandom_range(0, 5) == 0);
         exp_d = cfg_short ? {1'b0, d[6:0]} : d;
         idle(4);
         if (cfg_mp_en) begin
            logic mb;
            mb = $urandom_range(0, 1);
            send(d, 1, mb, !bad_s, 1);
            m_mpb = mb;
            exp_st = bad_s ? 8'h04 : 8'h01;
         end else if (cfg_par_en) begin
            send(d, 1, good_par(exp_d, cfg_par_odd) ^ bad_p, !bad_s, 1);
            exp_st = bad_s ? (bad_p ? 8'h0C : 8'h04) : (bad_p ? 8'h08 : 8'h01);
         end else begin
            send(d, 0, 0, !bad_s, 1);
            exp_st = bad_s ? 8'h04 : 8'h01;
         end
         exp_st[4] = m_mpb;
         rd(1'b1, rv); check("R4 R6 R7 R10 random status", rv, exp_st);
         rd(1'b0, rv); check("R3 random data", rv, exp_d);
         wr(4'h0);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule